// File: doc/BRIEF.md
# Filtered Event Performance Counter

This block is one slice of a performance-monitoring unit. Each cycle it receives a vector of sixteen small sub-event counts from one event source and the current privilege level of the code running. It keeps only the sub-events that software has enabled in a mask, and only when the privilege level is one that software has chosen to observe. It adds the surviving counts into one per-cycle increment. An optional filter stage can then replace that increment with a single count: the filter compares the increment against a threshold, can invert the result, and can keep only its rising edges. The result advances a 40-bit counter. Software can preset the counter to a negative value, so that it overflows after a chosen number of events.

Software reaches the block through a simple register bus with three locations. Address 0 holds the event-selection register, address 1 holds the counter-configuration register and address 2 holds the counter. All reads are combinational. A read of the counter returns either all 40 bits or only the low 32 bits. Each wrap of the counter gives a one-cycle overflow pulse, which is also driven out as a start signal for a partner slice. In cascade mode the counter stays idle until the partner's start signal arrives.

Top module: `pmc_slice`

## Requirements
- R1: After reset, reads of all three locations return zero, and incoming events do not change the counter.
- R2: Privilege gating depends on two bits of the event-selection register. When bit 2 is set, events at privilege levels 1, 2 and 3 are counted. When bit 3 is set, events at level 0 are counted. When both bits are set, events at every level are counted. When neither bit is set, no events are counted.
- R3: The event mask sits at bits 24:9 of the event-selection register, and mask bit k enables sub-event k. Sub-event k arrives on `ev_cnt[2k+1:2k]`. The per-cycle increment is the sum of the counts of all enabled sub-events.
- R4: The counter advances only while the enable flag (bit 12 of the configuration register) is set. Writing only the event-selection register starts no counting.
- R5: With compare (configuration bit 18) set and complement (bit 19) clear, a cycle whose increment is strictly greater than the threshold (bits 23:20) adds exactly one count. Any other cycle adds nothing.
- R6: With compare and complement both set, a cycle whose increment is less than or equal to the threshold adds exactly one count. With compare clear, complement has no effect and the raw increment is added.
- R7: With compare and edge (bit 24) set, only false-to-true transitions of the comparison add a count. The comparison history is cleared whenever enable or compare is clear, so the first true cycle after the counter is re-enabled counts.
- R8: A write to address 2 loads all 40 counter bits. With `reg_rd_low32` clear a counter read returns all 40 bits. With it set, the read returns the low 32 bits, zero-extended.
- R9: When an addition carries out of bit 39, the counter keeps the wrapped value. In the cycle after that edge, `ovf_pulse` and `casc_out` are high for exactly one cycle.
- R10: With the cascade flag (configuration bit 11) set, the enabled counter holds its value until `casc_in` has been sampled high. From the following cycle on it counts. Clearing enable re-arms this wait.
- R11: A counter write in the same cycle as a nonzero increment loads the written value, and that cycle's increment is lost.
- R12: Reserved bits read as zero. The event-selection register keeps bits 30:2. The configuration register keeps bits 15:11 and 24:18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Location: 0 event select, 1 configuration, 2 counter |
| reg_wdata | input | 40 | Write data |
| reg_rd_low32 | input | 1 | Counter read returns only the low 32 bits |
| reg_rdata | output | 40 | Combinational read data for `reg_addr` |
| ev_cnt | input | 32 | Sixteen 2-bit sub-event counts for this cycle |
| priv_lvl | input | 2 | Current privilege level, 0 being most privileged |
| casc_in | input | 1 | Start signal from the partner slice |
| casc_out | output | 1 | Start signal to the partner slice, pulsed on overflow |
| ovf_pulse | output | 1 | One-cycle overflow indication |

## Verification
A fault in the qualify or filter path shows up as a wrong counter value at the first read after the stimulus cycle. Every counted cycle reaches the counter register in the same clock, so the error is visible one edge later. A stale edge-detect history or a stuck cascade-start flag can hide until the counter is re-enabled. The bench therefore disables and re-enables the counter with the trigger held, and the error appears as a missing or extra count in the first cycle afterwards. A wrong wrap detector shows as a missing or misplaced `ovf_pulse` in the single cycle after the wrap edge.

// File: rtl/pmc_pkg.sv
// Shared widths, addresses and register field types for the counter slice.
// Assumes a single event source of NUM_SUB sub-events per slice.
package pmc_pkg;
    localparam int CNT_BITS = 40;
    localparam int NUM_SUB  = 16;
    localparam int SUB_W    = 2;
    localparam int THR_W    = 4;
    localparam int INC_W    = $clog2(NUM_SUB * ((1 << SUB_W) - 1) + 1);
    localparam int EV_W     = NUM_SUB * SUB_W;

    localparam logic [1:0] ADDR_EVSEL = 2'd0;
    localparam logic [1:0] ADDR_CFG   = 2'd1;
    localparam logic [1:0] ADDR_CNT   = 2'd2;

    // Event-selection register, packed so that it maps onto bits 30:2.
    typedef struct packed {
        logic [5:0]         class_sel;
        logic [NUM_SUB-1:0] mask;
        logic [3:0]         tag_val;
        logic               tag_en;
        logic               os;
        logic               usr;
    } evsel_t;

    // Configuration register fields (bit positions set in the top module).
    typedef struct packed {
        logic             edge_en;
        logic [THR_W-1:0] thr;
        logic             compl;
        logic             cmp;
        logic [2:0]       sel;
        logic             en;
        logic             casc;
    } cfg_t;
endpackage

// File: rtl/pmc_event_qual.sv
// Gates the sub-event counts by privilege and by mask, then sums them.
// Purely combinational; assumes priv level 0 is the most privileged.
module pmc_event_qual
    import pmc_pkg::*;
(
    input  logic [EV_W-1:0]    ev_cnt,
    input  logic [NUM_SUB-1:0] mask,
    input  logic               os,
    input  logic               usr,
    input  logic [1:0]         priv_lvl,
    output logic [INC_W-1:0]   inc
);
    logic               priv_ok;
    logic [INC_W-1:0]   part [NUM_SUB];

    // Privilege qualifier: level 0 needs os, any other level needs usr.
    always_comb priv_ok = (priv_lvl == 2'd0) ? os : usr;

    for (genvar k = 0; k < NUM_SUB; k++) begin : g_sub
        // Per-sub-event gate by its mask bit.
        always_comb part[k] = mask[k] ? INC_W'(ev_cnt[k*SUB_W +: SUB_W]) : '0;
    end

    // Adder over all gated sub-events.
    always_comb begin
        inc = '0;
        if (priv_ok) begin
            for (int k = 0; k < NUM_SUB; k++) inc = inc + part[k];
        end
    end
endmodule

// File: rtl/pmc_filter.sv
// Threshold / complement / rising-edge filter on the per-cycle increment.
// Assumes active follows the enable flag; history clears while inactive.
module pmc_filter
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             cmp_en,
    input  logic             compl,
    input  logic             edge_en,
    input  logic [THR_W-1:0] thr,
    input  logic [INC_W-1:0] inc_in,
    output logic [INC_W-1:0] inc_out
);
    logic hit;
    logic hit_prev_q;

    // Threshold comparison, optionally inverted.
    always_comb hit = compl ? (inc_in <= INC_W'(thr)) : (inc_in > INC_W'(thr));

    // Output select: raw, level-filtered or edge-filtered.
    always_comb begin
        if (!cmp_en)      inc_out = inc_in;
        else if (edge_en) inc_out = INC_W'(hit && !hit_prev_q);
        else              inc_out = INC_W'(hit);
    end

    // Comparison history, cleared whenever disabled or not comparing.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || !cmp_en) hit_prev_q <= 1'b0;
        else                              hit_prev_q <= hit;
    end

    // a_r7_edge_single: edge mode never delivers more than one count.
    a_r7_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && edge_en) |-> (inc_out <= INC_W'(1)));
    // a_r5_level_single: compare mode yields at most one count per cycle.
    a_r5_level_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |-> (inc_out <= INC_W'(1)));
endmodule

// File: rtl/pmc_counter.sv
// 40-bit presettable counter with wrap pulse and cascade-start gating.
// Assumes a write always wins over a same-cycle increment.
module pmc_counter
    import pmc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                casc_en,
    input  logic                casc_in,
    input  logic [INC_W-1:0]    inc,
    input  logic                wr,
    input  logic [CNT_BITS-1:0] wdata,
    output logic [CNT_BITS-1:0] cnt,
    output logic                ovf
);
    logic                started_q;
    logic                run;
    logic [CNT_BITS:0]   sum;

    // Counting is allowed when enabled and not waiting for a cascade start.
    always_comb run = en && (!casc_en || started_q);
    // Wide add exposing the carry out of the top bit.
    always_comb sum = {1'b0, cnt} + (CNT_BITS+1)'(inc);

    // Cascade start latch, re-armed when the counter is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)            started_q <= 1'b0;
        else if (casc_en && casc_in)  started_q <= 1'b1;
    end

    // Counter register and overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (wr) begin
            cnt <= wdata;
            ovf <= 1'b0;
        end else if (run) begin
            cnt <= sum[CNT_BITS-1:0];
            ovf <= sum[CNT_BITS];
        end else begin
            ovf <= 1'b0;
        end
    end

    // a_r4_idle_hold: without run or write the counter keeps its value.
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr) |=> $stable(cnt));
    // a_r11_write_wins: a write always lands exactly.
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt == $past(wdata)));
    // a_r9_ovf_small: right after a wrap the counter is below one increment.
    a_r9_ovf_small: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (cnt < CNT_BITS'(1 << INC_W)));
    // a_r10_casc_wait: an armed but unstarted cascade counter holds.
    a_r10_casc_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (en && casc_en && !started_q && !wr) |=> $stable(cnt));
endmodule

// File: rtl/pmc_slice.sv
// Top of the filtered event counter slice: register bus, field decode and
// wiring of qualify, filter and counter stages. Reads are combinational.
module pmc_slice
    import pmc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [CNT_BITS-1:0] reg_wdata,
    input  logic                reg_rd_low32,
    output logic [CNT_BITS-1:0] reg_rdata,
    input  logic [EV_W-1:0]     ev_cnt,
    input  logic [1:0]          priv_lvl,
    input  logic                casc_in,
    output logic                casc_out,
    output logic                ovf_pulse
);
    evsel_t              evsel_q;
    cfg_t                cfg_q;
    logic [INC_W-1:0]    qual_inc;
    logic [INC_W-1:0]    filt_inc;
    logic [CNT_BITS-1:0] cnt;
    logic                cnt_wr;

    // Counter write strobe decode.
    always_comb cnt_wr = reg_wr && (reg_addr == ADDR_CNT);

    // Event-selection register: bits 30:2 are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 evsel_q <= '0;
        else if (reg_wr && reg_addr == ADDR_EVSEL)  evsel_q <= reg_wdata[30:2];
    end

    // Configuration register: bits 15:11 and 24:18 are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else if (reg_wr && reg_addr == ADDR_CFG)
            cfg_q <= '{edge_en: reg_wdata[24], thr: reg_wdata[23:20],
                       compl: reg_wdata[19], cmp: reg_wdata[18],
                       sel: reg_wdata[15:13], en: reg_wdata[12],
                       casc: reg_wdata[11]};
    end

    // Read-data multiplexer.
    always_comb begin
        unique case (reg_addr)
            ADDR_EVSEL: reg_rdata = {9'd0, evsel_q, 2'd0};
            ADDR_CFG:   reg_rdata = {15'd0, cfg_q.edge_en, cfg_q.thr, cfg_q.compl,
                                     cfg_q.cmp, 2'd0, cfg_q.sel, cfg_q.en,
                                     cfg_q.casc, 11'd0};
            ADDR_CNT:   reg_rdata = reg_rd_low32 ? {8'd0, cnt[31:0]} : cnt;
            default:    reg_rdata = '0;
        endcase
    end

    pmc_event_qual u_qual (
        .ev_cnt   (ev_cnt),
        .mask     (evsel_q.mask),
        .os       (evsel_q.os),
        .usr      (evsel_q.usr),
        .priv_lvl (priv_lvl),
        .inc      (qual_inc)
    );

    pmc_filter u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (cfg_q.en),
        .cmp_en  (cfg_q.cmp),
        .compl   (cfg_q.compl),
        .edge_en (cfg_q.edge_en),
        .thr     (cfg_q.thr),
        .inc_in  (qual_inc),
        .inc_out (filt_inc)
    );

    pmc_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_q.en),
        .casc_en (cfg_q.casc),
        .casc_in (casc_in),
        .inc     (filt_inc),
        .wr      (cnt_wr),
        .wdata   (reg_wdata),
        .cnt     (cnt),
        .ovf     (ovf_pulse)
    );

    // Start signal to the partner is the overflow pulse.
    always_comb casc_out = ovf_pulse;

    // a_r2_priv_block: an unobserved privilege level leaves the counter alone.
    a_r2_priv_block: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.cmp && !cnt_wr &&
         !((priv_lvl == 2'd0) && evsel_q.os) &&
         !((priv_lvl != 2'd0) && evsel_q.usr)) |=> $stable(cnt));
    // a_r9_pulse_one: the overflow pulse never lasts two cycles.
    a_r9_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);
endmodule

// File: tb/tb_pmc_slice.sv
module tb_pmc_slice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [39:0] reg_wdata = '0;
    logic        reg_rd_low32 = 1'b0;
    logic [39:0] reg_rdata;
    logic [31:0] ev_cnt = '0;
    logic [1:0]  priv_lvl = 2'd0;
    logic        casc_in = 1'b0;
    logic        casc_out;
    logic        ovf_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pmc_slice dut (.*);

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [39:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic low, output logic [39:0] d);
        reg_addr = a; reg_rd_low32 = low;
        #1 d = reg_rdata;
        reg_rd_low32 = 1'b0;
    endtask

    task automatic run(input logic [31:0] ev, input logic [1:0] pl, input int n);
        ev_cnt = ev; priv_lvl = pl;
        repeat (n) @(negedge clk);
        ev_cnt = '0;
    endtask

    function automatic logic [31:0] fill(input int v);
        logic [31:0] r;
        for (int k = 0; k < 16; k++) r[2*k +: 2] = 2'(v);
        return r;
    endfunction

    function automatic int exp_sum(input logic [31:0] ev, input logic [15:0] m);
        int s = 0;
        for (int k = 0; k < 16; k++) if (m[k]) s += int'(ev[2*k +: 2]);
        return s;
    endfunction

    function automatic logic [39:0] evv(input logic os, input logic usr, input logic [15:0] m);
        return (40'(m) << 9) | (40'(os) << 3) | (40'(usr) << 2);
    endfunction

    function automatic logic [39:0] cfgv(input logic en, input logic casc, input logic cmp,
                                         input logic compl, input logic [3:0] thr,
                                         input logic edg);
        return (40'(edg) << 24) | (40'(thr) << 20) | (40'(compl) << 19) |
               (40'(cmp) << 18) | (40'(en) << 12) | (40'(casc) << 11);
    endfunction

    task automatic setup(input logic [39:0] e, input logic [39:0] c, input logic [39:0] preset);
        wr(2'd1, 40'd0);
        wr(2'd0, e);
        wr(2'd2, preset);
        wr(2'd1, c);
    endtask

    task automatic t_reset;
        logic [39:0] d;
        rd(2'd0, 0, d); check("R1 evsel", d, 0);
        rd(2'd1, 0, d); check("R1 cfg", d, 0);
        run(fill(3), 2'd0, 3);
        rd(2'd2, 0, d); check("R1 counter", d, 0);
    endtask

    task automatic t_enable;
        logic [39:0] d;
        wr(2'd0, evv(1, 1, 16'hFFFF));
        run(fill(1), 2'd0, 3);
        rd(2'd2, 0, d); check("R4 no enable", d, 0);
        wr(2'd1, cfgv(1, 0, 0, 0, 0, 0));
        run(fill(1), 2'd0, 3);
        rd(2'd2, 0, d); check("R4 enabled", d, 48);
    endtask

    task automatic t_mask;
        logic [39:0] d;
        logic [31:0] ev;
        ev = '0;
        for (int k = 0; k < 16; k++) ev[2*k +: 2] = 2'(k % 4);
        setup(evv(1, 0, 16'h8421), cfgv(1, 0, 0, 0, 0, 0), 0);
        run(ev, 2'd0, 2);
        rd(2'd2, 0, d); check("R3 mask 8421", d, 40'(2 * exp_sum(ev, 16'h8421)));
        setup(evv(1, 0, 16'h00FF), cfgv(1, 0, 0, 0, 0, 0), 0);
        run(fill(3), 2'd0, 1);
        rd(2'd2, 0, d); check("R3 mask 00FF", d, 40'(exp_sum(fill(3), 16'h00FF)));
    endtask

    task automatic t_priv;
        logic [39:0] d;
        setup(evv(0, 1, 16'h0001), cfgv(1, 0, 0, 0, 0, 0), 0);
        run(fill(1), 2'd0, 2);
        rd(2'd2, 0, d); check("R2 usr at 0", d, 0);
        run(fill(1), 2'd2, 2);
        rd(2'd2, 0, d); check("R2 usr at 2", d, 2);
        setup(evv(1, 0, 16'h0001), cfgv(1, 0, 0, 0, 0, 0), 0);
        run(fill(1), 2'd3, 2);
        rd(2'd2, 0, d); check("R2 os at 3", d, 0);
        run(fill(1), 2'd0, 3);
        rd(2'd2, 0, d); check("R2 os at 0", d, 3);
        setup(evv(0, 0, 16'h0001), cfgv(1, 0, 0, 0, 0, 0), 0);
        run(fill(1), 2'd0, 1); run(fill(1), 2'd1, 1);
        rd(2'd2, 0, d); check("R2 neither", d, 0);
    endtask

    task automatic t_thresh;
        logic [39:0] d;
        setup(evv(1, 1, 16'h0007), cfgv(1, 0, 1, 0, 4'd3, 0), 0);
        run(fill(1), 2'd0, 2);
        rd(2'd2, 0, d); check("R5 equal thr", d, 0);
        run(fill(2), 2'd0, 2);
        rd(2'd2, 0, d); check("R5 above thr", d, 2);
        run(fill(3), 2'd0, 1);
        rd(2'd2, 0, d); check("R5 well above", d, 3);
    endtask

    task automatic t_compl;
        logic [39:0] d;
        setup(evv(1, 1, 16'h0007), cfgv(1, 0, 1, 1, 4'd3, 0), 0);
        run(fill(1), 2'd0, 2);
        rd(2'd2, 0, d); check("R6 le thr", d, 2);
        run(fill(2), 2'd0, 2);
        rd(2'd2, 0, d); check("R6 gt thr", d, 2);
        setup(evv(1, 1, 16'h0007), cfgv(1, 0, 0, 1, 4'd3, 0), 0);
        run(fill(2), 2'd0, 2);
        rd(2'd2, 0, d); check("R6 compl no cmp", d, 12);
    endtask

    task automatic t_edge;
        logic [39:0] d;
        setup(evv(1, 1, 16'h0001), cfgv(1, 0, 1, 0, 4'd0, 1), 0);
        run(fill(1), 2'd0, 2);
        run(fill(0), 2'd0, 1);
        run(fill(2), 2'd0, 2);
        rd(2'd2, 0, d); check("R7 rising only", d, 2);
        ev_cnt = fill(2);
        wr(2'd2, 0);
        wr(2'd1, cfgv(0, 0, 1, 0, 4'd0, 1));
        wr(2'd1, cfgv(1, 0, 1, 0, 4'd0, 1));
        run(fill(2), 2'd0, 3);
        rd(2'd2, 0, d); check("R7 history cleared", d, 1);
    endtask

    task automatic t_readback;
        logic [39:0] d;
        wr(2'd1, 0);
        wr(2'd2, 40'hAB_1234_5678);
        rd(2'd2, 0, d); check("R8 full", d, 40'hAB_1234_5678);
        rd(2'd2, 1, d); check("R8 low32", d, 40'h00_1234_5678);
    endtask

    task automatic t_ovf;
        logic [39:0] d;
        setup(evv(1, 1, 16'h0001), cfgv(1, 0, 0, 0, 0, 0), 40'hFF_FFFF_FFFE);
        run(fill(1), 2'd0, 1);
        rd(2'd2, 0, d); check("R9 at max", d, 40'hFF_FFFF_FFFF);
        check("R9 no pulse yet", 40'(ovf_pulse), 0);
        run(fill(1), 2'd0, 1);
        rd(2'd2, 0, d); check("R9 wrapped", d, 0);
        check("R9 pulse", 40'(ovf_pulse), 1);
        check("R9 casc_out", 40'(casc_out), 1);
        @(negedge clk);
        check("R9 pulse ends", 40'(ovf_pulse), 0);
        setup(evv(1, 1, 16'h0001), cfgv(1, 0, 0, 0, 0, 0), 40'hFF_FFFF_FFFE);
        run(fill(3), 2'd0, 1);
        rd(2'd2, 0, d); check("R9 wrap by 3", d, 1);
        check("R9 pulse by 3", 40'(ovf_pulse), 1);
    endtask

    task automatic t_casc;
        logic [39:0] d;
        setup(evv(1, 1, 16'h0001), cfgv(1, 1, 0, 0, 0, 0), 0);
        run(fill(2), 2'd0, 3);
        rd(2'd2, 0, d); check("R10 waiting", d, 0);
        casc_in = 1'b1;
        @(negedge clk);
        casc_in = 1'b0;
        run(fill(2), 2'd0, 2);
        rd(2'd2, 0, d); check("R10 started", d, 4);
    endtask

    task automatic t_wrprio;
        logic [39:0] d;
        setup(evv(1, 1, 16'h0001), cfgv(1, 0, 0, 0, 0, 0), 0);
        ev_cnt = fill(1);
        wr(2'd2, 40'd100);
        rd(2'd2, 0, d); check("R11 write wins", d, 100);
        @(negedge clk);
        ev_cnt = '0;
        rd(2'd2, 0, d); check("R11 resumes", d, 101);
    endtask

    task automatic t_reserved;
        logic [39:0] d;
        wr(2'd1, 0);
        wr(2'd0, '1);
        rd(2'd0, 0, d); check("R12 evsel bits", d, 40'h00_7FFF_FFFC);
        wr(2'd1, '1);
        rd(2'd1, 0, d); check("R12 cfg bits", d, 40'h00_01FC_F800);
        wr(2'd1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_mask();
        t_priv();
        t_thresh();
        t_compl();
        t_edge();
        t_readback();
        t_ovf();
        t_casc();
        t_wrprio();
        t_reserved();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule